// File: doc/BRIEF.md
# Dual Connection-Memory Block Initializer

This block presets two connection memories, a local one and a backplane one, in a single pass after power-up. Software first sets a mode-enable bit in a control register. It then writes a pattern/start register that holds a start bit and two 3-bit patterns, one pattern for each memory. From the next clock on, the block writes one word per clock into both memories at the same address. Each word carries its memory's pattern in bits [15:13] and zeros in bits [12:0]. When the last word is written, the start bit drops back to 0 without software action, and that drop signals completion.

In normal service a connection-memory word selects a source channel in bits [7:0] and a source stream in bits [12:8]. At the lower rate this allows streams 0–31 with channels 0–127. At the higher rate it allows streams 0–15 with channels 0–255. A preset word therefore points every output at stream 0, channel 0, and its top three bits set that output's per-channel control. The normal host port that writes single words is blocked while a fill runs. Clearing either the start bit or mode-enable stops a fill at once. Both memories are modelled here as inferred RAMs with a combinational read port for inspection.

Top module: `conn_mem_fill`

## Requirements
- R1: After reset, mode-enable, the start bit, busy and both patterns are 0, and neither memory write port is active.
- R2: Writing the pattern/start register with the start bit (bit 0) at 1 while mode-enable is 0 starts nothing: busy stays 0 and the start bit reads back 0.
- R3: A fill writes {local pattern, 13'b0} into every local word, at addresses 0 to DEPTH-1.
- R4: The backplane memory receives {backplane pattern, 13'b0} at the same address and in the same clock as the local memory.
- R5: A fill writes word 0 on the clock after the start write and advances one address per clock. Busy stays high for exactly DEPTH clocks.
- R6: After the last word is written, busy and the start bit both return to 0 on their own.
- R7: Writing the start bit as 0 during a fill stops it. No write happens in that clock or in any later clock, and words that were not reached keep their earlier contents.
- R8: Writing mode-enable (control register bit 0) as 0 during a fill stops it in the same way, and mode-enable reads 0.
- R9: Host word writes (host_sel 0 selects local, 1 selects backplane) reach the memory when the block is idle. While busy they are ignored.
- R10: A fill of DEPTH words takes no more than CLK_HZ × 125 µs clocks.
- R11: Both patterns are 000 after reset, so starting a fill without loading them clears both memories to zero.
- R12: In the pattern/start register, bits [3:1] hold the local pattern and bits [6:4] hold the backplane pattern. These bits are taken only when the register is written while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0: control register, 1: pattern/start register |
| cfg_wdata | input | 7 | Register write data |
| mode_en | output | 1 | Mode-enable readback |
| start_flag | output | 1 | Start bit readback; drops to 0 on completion |
| loc_pat | output | 3 | Local pattern readback |
| bp_pat | output | 3 | Backplane pattern readback |
| busy | output | 1 | Fill in progress |
| host_we | input | 1 | Host single-word write |
| host_sel | input | 1 | Host target memory: 0 local, 1 backplane |
| host_addr | input | AW | Host write address |
| host_wdata | input | 16 | Host write data |
| loc_we | output | 1 | Local memory write enable |
| loc_addr | output | AW | Local memory write address |
| loc_wdata | output | 16 | Local memory write data |
| bp_we | output | 1 | Backplane memory write enable |
| bp_addr | output | AW | Backplane memory write address |
| bp_wdata | output | 16 | Backplane memory write data |
| rd_addr | input | AW | Inspection read address |
| rd_loc_data | output | 16 | Local memory word at rd_addr |
| rd_bp_data | output | 16 | Backplane memory word at rd_addr |

## Verification
A register write is taken at the clock edge inside the strobe. Busy and the start bit rise at that edge, word 0 is written at the next edge, and word k is written k edges later. The bench drives on falling edges and samples on the next falling edge. It counts falling edges while busy is high and expects exactly DEPTH. An abort is issued a known number of edges after the start, so the bench can predict exactly which addresses hold the new pattern and which keep the old one. Memory contents are read through the combinational port only while the block is idle.

// File: rtl/conn_mem_fill.sv
module conn_mem_fill #(
  parameter int DEPTH  = 4096,
  parameter int CLK_HZ = 100_000_000,
  localparam int AW     = $clog2(DEPTH),
  localparam int BUDGET = (CLK_HZ / 1_000_000) * 125
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [6:0]    cfg_wdata,
  output logic          mode_en,
  output logic          start_flag,
  output logic [2:0]    loc_pat,
  output logic [2:0]    bp_pat,
  output logic          busy,
  input  logic          host_we,
  input  logic          host_sel,
  input  logic [AW-1:0] host_addr,
  input  logic [15:0]   host_wdata,
  output logic          loc_we,
  output logic [AW-1:0] loc_addr,
  output logic [15:0]   loc_wdata,
  output logic          bp_we,
  output logic [AW-1:0] bp_addr,
  output logic [15:0]   bp_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_loc_data,
  output logic [15:0]   rd_bp_data
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt;
  logic [31:0]   run_cnt;
  logic [15:0]   mem_loc [DEPTH];
  logic [15:0]   mem_bp  [DEPTH];

  wire wr_ctrl = cfg_wr & ~cfg_sel;
  wire wr_pat  = cfg_wr &  cfg_sel;
  wire abort   = busy & (wr_ctrl | wr_pat) & ~cfg_wdata[0];
  wire go      = wr_pat & cfg_wdata[0] & mode_en & ~busy;
  wire fill    = busy & ~abort;
  wire last    = fill & (cnt == LAST);

  assign start_flag = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en <= 1'b0;
      loc_pat <= '0;
      bp_pat  <= '0;
      busy    <= 1'b0;
      cnt     <= '0;
      run_cnt <= '0;
    end else begin
      if (wr_ctrl) mode_en <= cfg_wdata[0];
      if (wr_pat && !busy) begin
        loc_pat <= cfg_wdata[3:1];
        bp_pat  <= cfg_wdata[6:4];
      end
      if (go) begin
        busy    <= 1'b1;
        cnt     <= '0;
        run_cnt <= '0;
      end else if (abort || last) begin
        busy <= 1'b0;
      end else if (fill) begin
        cnt     <= cnt + 1'b1;
        run_cnt <= run_cnt + 1;
      end
    end
  end

  assign loc_we    = fill | (~busy & host_we & ~host_sel);
  assign bp_we     = fill | (~busy & host_we &  host_sel);
  assign loc_addr  = busy ? cnt : host_addr;
  assign bp_addr   = busy ? cnt : host_addr;
  assign loc_wdata = busy ? {loc_pat, 13'd0} : host_wdata;
  assign bp_wdata  = busy ? {bp_pat,  13'd0} : host_wdata;

  always_ff @(posedge clk) begin
    if (loc_we) mem_loc[loc_addr] <= loc_wdata;
    if (bp_we)  mem_bp[bp_addr]   <= bp_wdata;
  end

  assign rd_loc_data = mem_loc[rd_addr];
  assign rd_bp_data  = mem_bp[rd_addr];

  a_r2_no_start_without_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pat && cfg_wdata[0] && !mode_en && !busy) |=> !busy);

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (loc_addr == AW'($past(loc_addr) + 1'b1)));

  a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (!busy && !start_flag));

  a_r7_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!loc_we && !bp_we));

  a_r8_mode_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl && !cfg_wdata[0]) |=> (!busy && !mode_en));

  a_r9_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we) |-> (loc_wdata[12:0] == 13'd0 && bp_wdata[12:0] == 13'd0));

  a_r10_budget: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < BUDGET));
endmodule

// File: tb/conn_mem_fill_tb.sv
module conn_mem_fill_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 512;
  localparam int CLK_HZ = 100_000_000;
  localparam int AW     = $clog2(DEPTH);
  localparam int BUDGET = (CLK_HZ / 1_000_000) * 125;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic mode_en, start_flag, busy;
  logic [2:0] loc_pat, bp_pat;
  logic host_we = 1'b0, host_sel = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic loc_we, bp_we;
  logic [AW-1:0] loc_addr, bp_addr;
  logic [15:0] loc_wdata, bp_wdata;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0] rd_loc_data, rd_bp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conn_mem_fill #(.DEPTH(DEPTH), .CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mode_en(mode_en), .start_flag(start_flag), .loc_pat(loc_pat), .bp_pat(bp_pat), .busy(busy),
    .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
    .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .bp_we(bp_we), .bp_addr(bp_addr), .bp_wdata(bp_wdata),
    .rd_addr(rd_addr), .rd_loc_data(rd_loc_data), .rd_bp_data(rd_bp_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic sel, input logic [6:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic host_write(input logic sel, input int a, input logic [15:0] d);
    host_we = 1'b1; host_sel = sel; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (busy && n < 4 * DEPTH) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic chk_range(input string req, input int lo, input int hi,
                           input logic [2:0] lp, input logic [2:0] bp);
    int bad = 0;
    logic [15:0] fa = '0, fe = '0;
    for (int i = lo; i <= hi; i++) begin
      rd_addr = AW'(i);
      #0.1;
      if (rd_loc_data !== {lp, 13'd0} || rd_bp_data !== {bp, 13'd0}) begin
        if (bad == 0) begin
          fa = (rd_loc_data !== {lp, 13'd0}) ? rd_loc_data : rd_bp_data;
          fe = (rd_loc_data !== {lp, 13'd0}) ? {lp, 13'd0} : {bp, 13'd0};
        end
        bad++;
      end
    end
    check(bad == 0, req, fa, fe);
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mode_en && !start_flag && !busy, "R1 flags", {mode_en, start_flag, busy}, 0);
    check(loc_pat == 0 && bp_pat == 0, "R1 patterns", {loc_pat, bp_pat}, 0);
    check(!loc_we && !bp_we, "R1 write ports", {loc_we, bp_we}, 0);
  endtask

  task automatic t_default_clear;
    int n;
    host_write(1'b0, 5, 16'hABCD);
    host_write(1'b1, 7, 16'h1357);
    rd_addr = AW'(5); #0.1;
    check(rd_loc_data == 16'hABCD, "R9 idle host write local", rd_loc_data, 16'hABCD);
    rd_addr = AW'(7); #0.1;
    check(rd_bp_data == 16'h1357, "R9 idle host write backplane", rd_bp_data, 16'h1357);
    @(negedge clk);
    cfg(1'b0, 7'd1);
    cfg(1'b1, 7'b000_000_1);
    check(busy && start_flag, "R5 busy after start", busy, 1);
    wait_done(n);
    check(n == DEPTH, "R5 fill length", n, DEPTH);
    check(n <= BUDGET, "R10 budget", n, BUDGET);
    check(!start_flag && !busy, "R6 self clear", start_flag, 0);
    chk_range("R11 default clear", 0, DEPTH - 1, 3'd0, 3'd0);
  endtask

  task automatic t_no_mode;
    cfg(1'b0, 7'd0);
    cfg(1'b1, {3'b011, 3'b110, 1'b1});
    check(!busy && !start_flag, "R2 start ignored", {busy, start_flag}, 0);
    check(loc_pat == 3'b110 && bp_pat == 3'b011, "R12 field positions", {loc_pat, bp_pat}, 8'h33);
    @(negedge clk);
    check(!loc_we && !bp_we, "R2 no writes", {loc_we, bp_we}, 0);
    chk_range("R2 memory unchanged", 0, 3, 3'd0, 3'd0);
  endtask

  task automatic t_fill;
    int n;
    cfg(1'b0, 7'd1);
    cfg(1'b1, {3'b101, 3'b010, 1'b1});
    check(loc_we && bp_we && loc_addr == 0 && bp_addr == 0, "R4 same address", bp_addr, 0);
    check(loc_wdata == 16'h4000 && bp_wdata == 16'hA000, "R4 concurrent data", bp_wdata, 16'hA000);
    @(negedge clk);
    check(loc_addr == 1 && bp_addr == 1, "R5 address step", loc_addr, 1);
    wait_done(n);
    check(n == DEPTH - 1, "R5 remaining length", n, DEPTH - 1);
    chk_range("R3 full pattern fill", 0, DEPTH - 1, 3'b010, 3'b101);
  endtask

  task automatic t_abort_start;
    cfg(1'b1, {3'b001, 3'b111, 1'b1});
    repeat (40) @(negedge clk);
    cfg(1'b1, {3'b000, 3'b000, 1'b0});
    check(!busy && !start_flag, "R7 abort stops", busy, 0);
    check(loc_pat == 3'b111, "R12 pattern held while busy", loc_pat, 3'b111);
    chk_range("R7 written part", 0, 39, 3'b111, 3'b001);
    chk_range("R7 untouched part", 40, DEPTH - 1, 3'b010, 3'b101);
  endtask

  task automatic t_abort_mode;
    cfg(1'b1, {3'b100, 3'b011, 1'b1});
    repeat (25) @(negedge clk);
    cfg(1'b0, 7'd0);
    check(!busy && !mode_en, "R8 mode abort", {busy, mode_en}, 0);
    chk_range("R8 written part", 0, 24, 3'b011, 3'b100);
    chk_range("R8 prior abort part", 25, 39, 3'b111, 3'b001);
    chk_range("R8 untouched part", 40, DEPTH - 1, 3'b010, 3'b101);
  endtask

  task automatic t_host_block;
    int n;
    cfg(1'b0, 7'd1);
    cfg(1'b1, {3'b110, 3'b110, 1'b1});
    host_we = 1'b1; host_sel = 1'b0; host_addr = AW'(100); host_wdata = 16'hFFFF;
    #1;
    check(loc_wdata == 16'hC000, "R9 busy blocks host data", loc_wdata, 16'hC000);
    @(negedge clk);
    host_we = 1'b0;
    wait_done(n);
    chk_range("R9 host write ignored", 100, 100, 3'b110, 3'b110);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_default_clear();
    t_no_mode();
    t_fill();
    t_abort_start();
    t_abort_mode();
    t_host_block();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule